// File: doc/BRIEF.md
# Scanline-Paced Video Memory Copy Engine

This block copies bytes from a 16-bit system address space into an 8 KB window of banked video memory. Software programs a source pointer, a destination pointer and a control byte through a byte-wide register port. The control byte picks the pacing and the length. In immediate mode the whole block moves back to back, one byte per clock. In paced mode the block is cut into 16-byte chunks, and each chunk waits for the start of a horizontal blanking interval.

The display timing logic drives a level that rises when line rendering ends. Each rising edge releases at most one chunk. The destination pointer is a full 16 bits wide and does not wrap: the byte written at 0xFFFF is the last one. When an incremented source pointer reaches 0xE000 or more, it is folded down into the 0xA000 to 0xBFFF range. A cancel that arrives after a chunk is already under way lets that chunk finish and then ends the transfer.

Top module: `hblank_vram_dma`

## Requirements
- R1: After reset, busy_o is 0, vram_we_o and src_re_o are 0, and len_rdata_o reads 0xFF.
- R2: Register offsets are 0 (source high byte), 1 (source low byte), 2 (destination high byte), 3 (destination low byte) and 4 (control). A high-byte write stores all 8 bits. A low-byte write keeps wdata[7:4], and bits [3:0] of that pointer become zero.
- R3: A control write starts a transfer of (wdata[6:0]+1)*16 bytes. wdata[7]=1 selects paced mode and wdata[7]=0 selects immediate mode. The one exception is the cancel case in R9 and R10.
- R4: In immediate mode one byte moves on every clock cycle, starting in the cycle after the control write, with no gaps.
- R5: Each byte is read at src_addr_o with src_re_o high and written in the same cycle. vram_addr_o is destination[12:0], vram_bank_o follows bank_i, and vram_wdata_o is src_data_i.
- R6: The byte written while the destination pointer is 0xFFFF ends the transfer, and no further bytes are written.
- R7: After each byte the source pointer increments. If the result is 0xE000 or more, it is ANDed with 0xBFFF.
- R8: In paced mode no byte moves until hblank_i rises. Each rising edge moves exactly 16 bytes, however long hblank_i stays high.
- R9: A control write with wdata[7]=0 during a paced transfer, with no chunk running and none starting in that cycle, stops the transfer at once.
- R10: The same cancel while a chunk is running, or in the cycle its edge arrives, lets that chunk complete and then ends the transfer.
- R11: len_rdata_o is {~busy, remaining 16-byte chunks minus one}, and reads 0xFF when idle.
- R12: busy_o rises only after a control write and falls once the remaining length reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| len_rdata_o | output | 8 | Status and remaining-length readback |
| busy_o | output | 1 | Transfer active |
| hblank_i | input | 1 | High from the end of line rendering through blanking |
| bank_i | input | 1 | Video memory bank select |
| src_re_o | output | 1 | Source read strobe |
| src_addr_o | output | 16 | Source read address |
| src_data_i | input | 8 | Source read data, same cycle |
| vram_we_o | output | 1 | Video memory write strobe |
| vram_bank_o | output | 1 | Bank of the write |
| vram_addr_o | output | 13 | Offset within the 8 KB window |
| vram_wdata_o | output | 8 | Write data |

## Verification
The assertions assume three things about the inputs. The pointer registers are not rewritten while a transfer runs. src_data_i is a combinational function of src_addr_o. Only a control write can start activity. The stimulus respects all three: it programs the pointers only while busy_o is low, and it waits for idle before each new control write, except in the deliberate cancel cases. Random pointers and lengths cover all three address regions, including pointers that start at or above the fold threshold.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  typedef enum logic [2:0] {
    REG_SRC_HI = 3'd0,
    REG_SRC_LO = 3'd1,
    REG_DST_HI = 3'd2,
    REG_DST_LO = 3'd3,
    REG_CTRL   = 3'd4
  } hdma_reg_e;

  localparam logic [15:0] FOLD_LIMIT = 16'hE000;
  localparam logic [15:0] FOLD_MASK  = 16'hBFFF;

  function automatic logic [15:0] fold_src(input logic [15:0] a);
    return (a >= FOLD_LIMIT) ? (a & FOLD_MASK) : a;
  endfunction
endpackage

// File: rtl/hdma_edge.sv
module hdma_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/hdma_addr.sv
module hdma_addr #(
  parameter int ADDR_W  = 16,
  parameter int VRAM_AW = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  input  logic               step_i,
  output logic [ADDR_W-1:0]  src_o,
  output logic [VRAM_AW-1:0] vram_addr_o,
  output logic               dst_last_o
);
  import hdma_pkg::*;

  logic [ADDR_W-1:0] src_q, dst_q;

  assign dst_last_o  = &dst_q;
  assign src_o       = src_q;
  assign vram_addr_o = dst_q[VRAM_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (step_i) begin
      // pointers freeze on the final address
      if (!dst_last_o) begin
        dst_q <= dst_q + 1'b1;
        src_q <= fold_src(src_q + 1'b1);
      end
    end else if (reg_we_i) begin
      case (reg_addr_i)
        REG_SRC_HI: src_q[15:8] <= reg_wdata_i;
        REG_SRC_LO: src_q[7:0]  <= {reg_wdata_i[7:4], 4'h0};
        REG_DST_HI: dst_q       <= {reg_wdata_i, dst_q[7:4], 4'h0};
        REG_DST_LO: dst_q[7:0]  <= {reg_wdata_i[7:4], 4'h0};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hdma_ctrl.sv
module hdma_ctrl #(
  parameter int CHUNK = 16,
  parameter int LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [LEN_W:0]   ctl_wdata_i,
  input  logic             hbl_rise_i,
  input  logic             dst_last_i,
  output logic             xfer_o,
  output logic             busy_o,
  output logic [LEN_W:0]   rdata_o
);
  localparam int SHIFT   = $clog2(CHUNK);
  localparam int BYTES_W = LEN_W + SHIFT + 1;
  localparam int CNT_W   = SHIFT + 1;

  logic               active_q, active_d;
  logic               paced_q, paced_d;
  logic [BYTES_W-1:0] len_q, len_d, chunks_m1;
  logic [CNT_W-1:0]   chunk_q, chunk_d;
  logic               go;

  assign xfer_o = active_q && (len_q != '0) && (!paced_q || chunk_q != '0);
  assign go     = active_q && paced_q && hbl_rise_i && (len_q != '0) && (chunk_q == '0);

  always_comb begin
    len_d    = len_q;
    chunk_d  = chunk_q;
    active_d = active_q;
    paced_d  = paced_q;
    if (xfer_o) begin
      if (dst_last_i) begin
        len_d   = '0;
        chunk_d = '0;
      end else begin
        len_d = len_q - 1'b1;
        if (paced_q) chunk_d = chunk_q - 1'b1;
      end
    end
    if (go) chunk_d = CNT_W'(CHUNK);
    if (ctl_we_i) begin
      if (!ctl_wdata_i[LEN_W] && active_q && paced_q) begin
        // committed chunk becomes the last one
        if (chunk_d != '0) len_d = BYTES_W'(chunk_d);
        else               len_d = '0;
      end else begin
        paced_d  = ctl_wdata_i[LEN_W];
        len_d    = (BYTES_W'(ctl_wdata_i[LEN_W-1:0]) + BYTES_W'(1)) << SHIFT;
        chunk_d  = '0;
        active_d = 1'b1;
      end
    end
    active_d = active_d && (len_d != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      paced_q  <= 1'b0;
      len_q    <= '0;
      chunk_q  <= '0;
    end else begin
      active_q <= active_d;
      paced_q  <= paced_d;
      len_q    <= len_d;
      chunk_q  <= chunk_d;
    end
  end

  assign chunks_m1 = (len_q - 1'b1) >> SHIFT;
  assign busy_o    = active_q;
  assign rdata_o   = active_q ? {1'b0, chunks_m1[LEN_W-1:0]} : '1;
endmodule

// File: rtl/hblank_vram_dma.sv
module hblank_vram_dma #(
  parameter int ADDR_W  = 16,
  parameter int VRAM_AW = 13,
  parameter int CHUNK   = 16,
  parameter int LEN_W   = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         len_rdata_o,
  output logic               busy_o,
  input  logic               hblank_i,
  input  logic               bank_i,
  output logic               src_re_o,
  output logic [ADDR_W-1:0]  src_addr_o,
  input  logic [7:0]         src_data_i,
  output logic               vram_we_o,
  output logic               vram_bank_o,
  output logic [VRAM_AW-1:0] vram_addr_o,
  output logic [7:0]         vram_wdata_o
);
  import hdma_pkg::*;

  logic hbl_rise, xfer, dst_last, ctl_we;

  assign ctl_we = reg_we_i && (reg_addr_i == REG_CTRL);

  hdma_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (hblank_i),
    .rise_o (hbl_rise)
  );

  hdma_addr #(.ADDR_W(ADDR_W), .VRAM_AW(VRAM_AW)) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .step_i      (xfer),
    .src_o       (src_addr_o),
    .vram_addr_o (vram_addr_o),
    .dst_last_o  (dst_last)
  );

  hdma_ctrl #(.CHUNK(CHUNK), .LEN_W(LEN_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we),
    .ctl_wdata_i (reg_wdata_i),
    .hbl_rise_i  (hbl_rise),
    .dst_last_i  (dst_last),
    .xfer_o      (xfer),
    .busy_o      (busy_o),
    .rdata_o     (len_rdata_o)
  );

  assign src_re_o     = xfer;
  assign vram_we_o    = xfer;
  assign vram_bank_o  = bank_i;
  assign vram_wdata_o = src_data_i;
endmodule

// File: rtl/hdma_checker.sv
module hdma_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        busy_o,
  input logic [7:0]  len_rdata_o,
  input logic        src_re_o,
  input logic [15:0] src_addr_o,
  input logic        vram_we_o,
  input logic [12:0] vram_addr_o
);
  assert_write_needs_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |-> busy_o);

  assert_busy_starts_on_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(reg_we_i));

  assert_read_with_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_re_o == vram_we_o);

  assert_dst_consecutive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_we_o && $past(vram_we_o)) |-> (vram_addr_o == $past(vram_addr_o) + 13'd1));

  assert_src_folded_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_re_o && $past(src_re_o)) |-> (src_addr_o < 16'hE000));

  assert_len_no_growth_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(reg_we_i)) |-> (len_rdata_o[6:0] <= $past(len_rdata_o[6:0])));
endmodule

bind hblank_vram_dma hdma_checker i_hdma_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .busy_o      (busy_o),
  .len_rdata_o (len_rdata_o),
  .src_re_o    (src_re_o),
  .src_addr_o  (src_addr_o),
  .vram_we_o   (vram_we_o),
  .vram_addr_o (vram_addr_o)
);

// File: tb/test_hblank_vram_dma.sv
module test_hblank_vram_dma;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  len_rdata;
  logic        busy;
  logic        hblank = 1'b0;
  logic        bank = 1'b0;
  logic        src_re;
  logic [15:0] src_addr;
  logic [7:0]  src_data;
  logic        vram_we;
  logic        vram_bank;
  logic [12:0] vram_addr;
  logic [7:0]  vram_wdata;

  int checks = 0;
  int errors = 0;
  int log_n = 0;
  logic [13:0] log_a [LOG_N];
  logic [7:0]  log_d [LOG_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] fold(input logic [15:0] a);
    return (a >= 16'hE000) ? (a & 16'hBFFF) : a;
  endfunction

  assign src_data = src_byte(src_addr);

  hblank_vram_dma i_hblank_vram_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .len_rdata_o(len_rdata), .busy_o(busy),
    .hblank_i(hblank), .bank_i(bank), .src_re_o(src_re), .src_addr_o(src_addr),
    .src_data_i(src_data), .vram_we_o(vram_we), .vram_bank_o(vram_bank),
    .vram_addr_o(vram_addr), .vram_wdata_o(vram_wdata)
  );

  always @(negedge clk) begin
    if (rst_n && vram_we && log_n < LOG_N) begin
      log_a[log_n] = {vram_bank, vram_addr};
      log_d[log_n] = vram_wdata;
      log_n = log_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ptrs(input logic [15:0] s, input logic [15:0] d);
    wr(3'd0, s[15:8]); wr(3'd1, s[7:0]);
    wr(3'd2, d[15:8]); wr(3'd3, d[7:0]);
  endtask

  task automatic pulse(input int high);
    @(negedge clk);
    hblank = 1'b1;
    repeat (high) @(negedge clk);
    hblank = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // compare log from base against the model of a copy of nb bytes
  task automatic expect_copy(input logic [15:0] s0, input logic [15:0] d0, input int nb,
                             input int base, input string req);
    logic [15:0] s = s0 & 16'hFFF0;
    logic [15:0] d = d0 & 16'hFFF0;
    int n = 0;
    int bad = 0;
    for (int i = 0; i < nb; i++) begin
      if (base + n < log_n) begin
        if (log_a[base+n] != {bank, d[12:0]} || log_d[base+n] != src_byte(s)) begin
          if (bad == 0)
            $display("FAIL %s byte %0d actual=0x%0h/0x%0h expected=0x%0h/0x%0h", req, n,
                     log_a[base+n], log_d[base+n], {bank, d[12:0]}, src_byte(s));
          bad++;
        end
      end
      n++;
      if (d == 16'hFFFF) break;
      d = d + 16'd1;
      s = fold(s + 16'd1);
    end
    checks++;
    if (bad != 0) errors++;
    check(log_n - base == n, {req, " count"}, log_n - base, n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset
    check(!busy, "R1 busy", busy, 0);
    check(!vram_we && !src_re, "R1 strobes", vram_we, 0);
    check(len_rdata == 8'hFF, "R1 readback", len_rdata, 8'hFF);

    // R4 R5 R2 R3 immediate copy, low nibbles dropped
    bank = 1'b1;
    set_ptrs(16'h4327, 16'h8A5F);
    base = log_n;
    wr(3'd4, 8'h03);
    check(busy && len_rdata == 8'h03, "R11 readback start", len_rdata, 8'h03);
    repeat (70) @(negedge clk);
    expect_copy(16'h4327, 16'h8A5F, 64, base, "R4");
    check(!busy && len_rdata == 8'hFF, "R12 idle after", len_rdata, 8'hFF);

    // R6 destination end
    bank = 1'b0;
    set_ptrs(16'h1000, 16'hFFE0);
    base = log_n;
    wr(3'd4, 8'h03);
    repeat (70) @(negedge clk);
    expect_copy(16'h1000, 16'hFFE0, 64, base, "R6");
    check(log_a[log_n-1] == 14'h1FFF, "R6 last addr", log_a[log_n-1], 14'h1FFF);
    check(!busy, "R6 stopped", busy, 0);

    // R7 source fold
    set_ptrs(16'hDFF0, 16'h8000);
    base = log_n;
    wr(3'd4, 8'h01);
    repeat (40) @(negedge clk);
    expect_copy(16'hDFF0, 16'h8000, 32, base, "R7");
    check(log_d[base+16] == src_byte(16'hA000), "R7 folded byte", log_d[base+16], src_byte(16'hA000));

    // R8 paced copy
    set_ptrs(16'h2000, 16'h9000);
    base = log_n;
    wr(3'd4, 8'h82);
    repeat (30) @(negedge clk);
    check(log_n == base, "R8 wait for edge", log_n - base, 0);
    pulse(40);
    check(log_n - base == 16, "R8 one chunk per edge", log_n - base, 16);
    check(len_rdata == 8'h01, "R11 remaining", len_rdata, 8'h01);
    pulse(2);
    pulse(2);
    expect_copy(16'h2000, 16'h9000, 48, base, "R8");
    check(!busy && len_rdata == 8'hFF, "R12 paced done", len_rdata, 8'hFF);

    // R9 cancel before chunk
    set_ptrs(16'h3000, 16'h9100);
    base = log_n;
    wr(3'd4, 8'h83);
    pulse(2);
    wr(3'd4, 8'h00);
    check(!busy && len_rdata == 8'hFF, "R9 stopped", len_rdata, 8'hFF);
    pulse(2);
    check(log_n - base == 16, "R9 no more bytes", log_n - base, 16);

    // R10 cancel one cycle after the edge
    set_ptrs(16'h3400, 16'h9200);
    base = log_n;
    wr(3'd4, 8'h83);
    @(negedge clk);
    hblank = 1'b1;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00;
    @(negedge clk);
    reg_we = 1'b0; hblank = 1'b0;
    repeat (25) @(negedge clk);
    check(log_n - base == 16, "R10 chunk finished", log_n - base, 16);
    check(!busy, "R10 ended", busy, 0);
    pulse(2);
    check(log_n - base == 16, "R10 no next chunk", log_n - base, 16);

    // R10 cancel in the edge cycle itself
    set_ptrs(16'h3800, 16'h9300);
    base = log_n;
    wr(3'd4, 8'h83);
    @(negedge clk);
    hblank = 1'b1;
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00;
    @(negedge clk);
    reg_we = 1'b0; hblank = 1'b0;
    repeat (25) @(negedge clk);
    expect_copy(16'h3800, 16'h9300, 16, base, "R10 edge cycle");
    check(!busy, "R10 edge ended", busy, 0);

    // random transfers
    for (int it = 0; it < 12; it++) begin
      logic [15:0] s = 16'($urandom);
      logic [15:0] d = 16'($urandom);
      logic [2:0]  lf = 3'($urandom);
      logic        pm = 1'($urandom);
      if (it % 4 == 0) d = 16'hFF00 | 16'($urandom_range(0, 255));
      if (it % 4 == 1) s = 16'hDF80 | 16'($urandom_range(0, 127));
      bank = 1'($urandom);
      set_ptrs(s, d);
      base = log_n;
      wr(3'd4, {pm, 4'h0, lf});
      if (pm) begin
        for (int p = 0; p < 10 && busy; p++) pulse(1 + p % 3);
      end else begin
        repeat (140) @(negedge clk);
      end
      expect_copy(s, d, (lf + 1) * 16, base, pm ? "R8 random" : "R4 random");
      check(!busy, "R12 random idle", busy, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule